// File: doc/BRIEF.md
# Transmit Elastic Buffer with Controlled Frame Slip

This block sits between a 32-timeslot backplane byte stream and a 24-timeslot DS1 transmit frame that runs on its own timebase. Backplane bytes arrive on a valid/ready write stream. A subset of timeslots is kept: the first stored timeslot index is a parameter, and a run of `SLOTS` consecutive timeslots is stored. Those bytes go into a buffer that holds two DS1 frames. The DS1 side pulls bytes one per read beat and is told which byte opens a frame. Both sides run in one fast clock. Each side advances only on its own handshake, so the two sides may run at different average rates.

The block keeps a delay figure: the number of stored bytes that have not yet been read. It checks this figure each time the read side crosses a frame boundary. If the reader has come too close to the writer, the reader steps back one whole frame and sends that frame again. If too many bytes are waiting, the reader jumps forward one whole frame and that frame is lost. Each such controlled slip does three things. It toggles a status bit. It records the direction. It raises a one-cycle interrupt pulse, which a mask input can suppress. The delay seen at each boundary is published. Software can also preset the delay, which moves the read frame boundary.

Back-pressure rules: the write stream never stalls after reset (`wr_ready` is high whenever reset is low), because overflow is resolved by slips and not by flow control. The read stream always offers a byte after reset (`rd_valid` is high whenever reset is low), and the DS1 timebase consumes one byte on each cycle in which it raises `rd_ready`.

Top module: `tx_slip_buffer`

## Requirements
- R1: While `rst` is high, `wr_ready`, `rd_valid`, `slip_irq`, `slip_stat`, `slip_dir` and `dly_meas` are all 0, and both buffer positions return to 0. After reset is released, `wr_ready` and `rd_valid` are 1.
- R2: Each write beat is assigned a backplane timeslot. The timeslot is 0 when `wr_sof` is 1; otherwise it is one more than the previous beat's timeslot, modulo 32. Only beats in timeslots 1 to 24 are stored, in arrival order. Other beats are dropped. The write side is never back-pressured.
- R3: `rd_data` shows the byte at the read position. Each read beat (`rd_valid && rd_ready`) moves the read position forward by one, modulo 48. `rd_sof` is 1 exactly when the read position is 0 or 24. With no read beat and no preset, the read position holds.
- R4: The delay d is (write position minus read position) modulo 48, using the write position before this cycle's store. When a read beat moves the read position onto a frame boundary and d is less than `NEAR_GAP` (default 4), the position instead moves a further 24. The previous frame is then sent again (repeat).
- R5: In the same situation, if d is greater than `MAX_DLY` (default 40), the position also moves a further 24. One frame of stored bytes is then passed over (skip).
- R6: Each slip toggles `slip_stat`. It sets `slip_dir` to 1 for a repeat and 0 for a skip. It pulses `slip_irq` for one cycle unless `irq_mask` was 1 on that edge.
- R7: At each read frame boundary, `dly_meas` takes the delay that remains after any slip.
- R8: When `cfg_dly_we` is 1, the read position is set so that the delay equals min(`cfg_dly`, 23), and `dly_meas` shows that value on the next cycle. A preset takes priority over a read beat in the same cycle.
- R9: No slip occurs at a boundary where d lies between `NEAR_GAP` and `MAX_DLY` inclusive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock shared by both sides |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Backplane byte present |
| wr_ready | output | 1 | Write side accepts (high after reset) |
| wr_sof | input | 1 | Marks backplane timeslot 0 |
| wr_data | input | 8 | Backplane byte |
| rd_valid | output | 1 | Read byte offered (high after reset) |
| rd_ready | input | 1 | Read strobe from the DS1 timebase |
| rd_sof | output | 1 | Offered byte is the first of a DS1 frame |
| rd_data | output | 8 | Offered DS1 byte |
| cfg_dly_we | input | 1 | Preset strobe |
| cfg_dly | input | 6 | Preset delay in bytes |
| dly_meas | output | 6 | Delay captured at the last frame boundary or preset |
| irq_mask | input | 1 | Suppresses the slip interrupt |
| slip_irq | output | 1 | One-cycle slip interrupt |
| slip_stat | output | 1 | Toggles on every slip |
| slip_dir | output | 1 | 1 after a repeat, 0 after a skip |

## Verification
The hardest situation to reach is a skip. A skip needs the write side to outpace the reader by more than `MAX_DLY` bytes, yet the delay must not wrap past the buffer size between two boundary checks. The stimulus gets there by keeping a full-rate backplane stream and lowering the read strobe to two beats in three. The delay then grows by about three bytes per DS1 frame and crosses the threshold cleanly. A repeat is reached in the opposite way, with the reader at seven beats in eight, after a period of matched rates from a preset offset shows that the band between the thresholds causes no slip.

// File: rtl/tsb_pkg.sv
package tsb_pkg;
  typedef enum logic [1:0] {
    SLIP_NONE   = 2'd0,
    SLIP_REPEAT = 2'd1,
    SLIP_SKIP   = 2'd2
  } slip_kind_e;
endpackage

// File: rtl/tsb_wr_ctrl.sv
module tsb_wr_ctrl #(
  parameter int BP_SLOTS = 32,
  parameter int SLOTS    = 24,
  parameter int TS_FIRST = 1,
  parameter int DEPTH    = 48,
  parameter int PW       = 6,
  parameter int BSW      = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          beat,
  input  logic          sof,
  output logic          store_en,
  output logic [PW-1:0] wpos
);
  logic [BSW-1:0] next_slot;
  logic [BSW-1:0] cur_slot;

  always_comb begin
    cur_slot = sof ? '0 : next_slot;
    store_en = beat && (int'(cur_slot) >= TS_FIRST) && (int'(cur_slot) < TS_FIRST + SLOTS);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      next_slot <= '0;
      wpos      <= '0;
    end else begin
      if (beat) begin
        if (int'(cur_slot) == BP_SLOTS - 1) next_slot <= '0;
        else next_slot <= cur_slot + 1'b1;
      end
      if (store_en) begin
        if (int'(wpos) == DEPTH - 1) wpos <= '0;
        else wpos <= wpos + 1'b1;
      end
    end
  end
endmodule

// File: rtl/tsb_store.sv
module tsb_store #(
  parameter int DW    = 8,
  parameter int DEPTH = 48,
  parameter int PW    = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [PW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [PW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] cells [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_cell
    always_ff @(posedge clk) begin
      if (rst) cells[g] <= '0;
      else if (we && int'(waddr) == g) cells[g] <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    if (int'(raddr) < DEPTH) rdata = cells[raddr];
  end
endmodule

// File: rtl/tsb_rd_ctrl.sv
module tsb_rd_ctrl
  import tsb_pkg::*;
#(
  parameter int SLOTS    = 24,
  parameter int DEPTH    = 48,
  parameter int PW       = 6,
  parameter int NEAR_GAP = 4,
  parameter int MAX_DLY  = 40
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step,
  input  logic          cfg_we,
  input  logic [PW-1:0] cfg_dly,
  input  logic          irq_mask,
  input  logic [PW-1:0] wpos,
  output logic [PW-1:0] rpos,
  output logic          frame_start,
  output logic [PW-1:0] dly_meas,
  output logic          slip_irq,
  output logic          slip_stat,
  output logic          slip_dir
);
  localparam int PX = PW + 1;

  logic [PW-1:0] cand;
  logic          at_bound;
  logic [PX-1:0] gap;
  logic [PW-1:0] gap_n;
  logic [PW-1:0] cand_far;
  logic [PW-1:0] gap_far;
  logic [PW-1:0] preset_val;
  logic [PX-1:0] preset_sum;
  logic [PW-1:0] preset_pos;
  slip_kind_e    kind;

  function automatic logic [PW-1:0] mod_sub(input logic [PW-1:0] a, input logic [PW-1:0] b);
    logic [PX-1:0] t;
    t = {1'b0, a} + PX'(DEPTH) - {1'b0, b};
    if (int'(t) >= DEPTH) t = t - PX'(DEPTH);
    return t[PW-1:0];
  endfunction

  function automatic logic [PW-1:0] frame_hop(input logic [PW-1:0] p);
    if (int'(p) >= SLOTS) return p - PW'(SLOTS);
    else return p + PW'(SLOTS);
  endfunction

  always_comb begin
    cand     = (int'(rpos) == DEPTH - 1) ? '0 : rpos + 1'b1;
    at_bound = (int'(cand) == 0) || (int'(cand) == SLOTS);
    gap      = {1'b0, mod_sub(wpos, cand)};
    gap_n    = gap[PW-1:0];
    kind     = SLIP_NONE;
    if (at_bound) begin
      if (int'(gap) < NEAR_GAP) kind = SLIP_REPEAT;
      else if (int'(gap) > MAX_DLY) kind = SLIP_SKIP;
    end
    cand_far = frame_hop(cand);
    gap_far  = mod_sub(wpos, cand_far);
  end

  always_comb begin
    preset_val = (int'(cfg_dly) > SLOTS - 1) ? PW'(SLOTS - 1) : cfg_dly;
    preset_sum = {1'b0, wpos} + PX'(DEPTH) - {1'b0, preset_val};
    if (int'(preset_sum) >= DEPTH) preset_sum = preset_sum - PX'(DEPTH);
    preset_pos = preset_sum[PW-1:0];
  end

  assign frame_start = (int'(rpos) == 0) || (int'(rpos) == SLOTS);

  always_ff @(posedge clk) begin
    if (rst) begin
      rpos      <= '0;
      dly_meas  <= '0;
      slip_irq  <= 1'b0;
      slip_stat <= 1'b0;
      slip_dir  <= 1'b0;
    end else begin
      slip_irq <= 1'b0;
      if (cfg_we) begin
        rpos     <= preset_pos;
        dly_meas <= preset_val;
      end else if (step) begin
        if (kind == SLIP_NONE) begin
          rpos <= cand;
          if (at_bound) dly_meas <= gap_n;
        end else begin
          rpos      <= cand_far;
          dly_meas  <= gap_far;
          slip_stat <= ~slip_stat;
          slip_dir  <= (kind == SLIP_REPEAT);
          slip_irq  <= ~irq_mask;
        end
      end
    end
  end
endmodule

// File: rtl/tx_slip_buffer.sv
module tx_slip_buffer #(
  parameter int DW       = 8,
  parameter int SLOTS    = 24,
  parameter int BP_SLOTS = 32,
  parameter int TS_FIRST = 1,
  parameter int NEAR_GAP = 4,
  parameter int MAX_DLY  = 40,
  parameter int PW       = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic          wr_sof,
  input  logic [DW-1:0] wr_data,
  output logic          rd_valid,
  input  logic          rd_ready,
  output logic          rd_sof,
  output logic [DW-1:0] rd_data,
  input  logic          cfg_dly_we,
  input  logic [PW-1:0] cfg_dly,
  output logic [PW-1:0] dly_meas,
  input  logic          irq_mask,
  output logic          slip_irq,
  output logic          slip_stat,
  output logic          slip_dir
);
  localparam int DEPTH = 2 * SLOTS;
  localparam int BSW   = $clog2(BP_SLOTS);

  logic          wbeat;
  logic          rstep;
  logic          store_en;
  logic [PW-1:0] wpos;
  logic [PW-1:0] rpos;

  assign wr_ready = ~rst;
  assign rd_valid = ~rst;
  assign wbeat    = wr_valid & wr_ready;
  assign rstep    = rd_valid & rd_ready;

  tsb_wr_ctrl #(
    .BP_SLOTS(BP_SLOTS), .SLOTS(SLOTS), .TS_FIRST(TS_FIRST),
    .DEPTH(DEPTH), .PW(PW), .BSW(BSW)
  ) u_wr (
    .clk(clk), .rst(rst), .beat(wbeat), .sof(wr_sof),
    .store_en(store_en), .wpos(wpos)
  );

  tsb_store #(.DW(DW), .DEPTH(DEPTH), .PW(PW)) u_store (
    .clk(clk), .rst(rst), .we(store_en), .waddr(wpos), .wdata(wr_data),
    .raddr(rpos), .rdata(rd_data)
  );

  tsb_rd_ctrl #(
    .SLOTS(SLOTS), .DEPTH(DEPTH), .PW(PW),
    .NEAR_GAP(NEAR_GAP), .MAX_DLY(MAX_DLY)
  ) u_rd (
    .clk(clk), .rst(rst), .step(rstep), .cfg_we(cfg_dly_we), .cfg_dly(cfg_dly),
    .irq_mask(irq_mask), .wpos(wpos), .rpos(rpos), .frame_start(rd_sof),
    .dly_meas(dly_meas), .slip_irq(slip_irq), .slip_stat(slip_stat),
    .slip_dir(slip_dir)
  );
endmodule

// File: rtl/tsb_chk.sv
module tsb_chk #(
  parameter int SLOTS   = 24,
  parameter int MAX_DLY = 40,
  parameter int PW      = 6
) (
  input logic          clk,
  input logic          rst,
  input logic          rd_ready,
  input logic          rd_sof,
  input logic          cfg_dly_we,
  input logic [PW-1:0] cfg_dly,
  input logic [PW-1:0] dly_meas,
  input logic          irq_mask,
  input logic          slip_irq,
  input logic          slip_stat
);
  logic rst_d;
  always_ff @(posedge clk) rst_d <= rst;

  // R1: state is cleared on the cycle reset is released
  always @(posedge clk) begin
    if (!rst && rst_d === 1'b1)
      a_r1_reset_clear: assert (!slip_irq && !slip_stat && dly_meas == '0);
  end

  // R6: an interrupt pulse always comes with a status toggle
  a_r6_irq_toggles: assert property (@(posedge clk) disable iff (rst)
    slip_irq |-> !$stable(slip_stat));

  // R6: a masked edge never produces an interrupt
  a_r6_mask: assert property (@(posedge clk) disable iff (rst)
    (irq_mask && !cfg_dly_we) |=> !slip_irq);

  // R8: a preset is reflected in the measurement, clamped below one frame
  a_r8_preset: assert property (@(posedge clk) disable iff (rst)
    cfg_dly_we |=> dly_meas == ((int'($past(cfg_dly)) > SLOTS - 1) ? PW'(SLOTS - 1) : $past(cfg_dly)));

  // R7: the published delay never exceeds the skip threshold
  a_r7_meas_range: assert property (@(posedge clk) disable iff (rst)
    int'(dly_meas) <= MAX_DLY);

  // R3: without a read beat or preset the frame marker holds
  a_r3_hold: assert property (@(posedge clk) disable iff (rst)
    (!rd_ready && !cfg_dly_we) |=> $stable(rd_sof));
endmodule

bind tx_slip_buffer tsb_chk #(.SLOTS(SLOTS), .MAX_DLY(MAX_DLY), .PW(PW)) u_chk (
  .clk(clk), .rst(rst), .rd_ready(rd_ready), .rd_sof(rd_sof),
  .cfg_dly_we(cfg_dly_we), .cfg_dly(cfg_dly), .dly_meas(dly_meas),
  .irq_mask(irq_mask), .slip_irq(slip_irq), .slip_stat(slip_stat)
);

// File: tb/tx_slip_buffer_bench.sv
module tx_slip_buffer_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_valid = 1'b0, wr_sof = 1'b0, rd_ready = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       cfg_dly_we = 1'b0, irq_mask = 1'b0;
  logic [5:0] cfg_dly = 6'd0;
  logic       wr_ready, rd_valid, rd_sof, slip_irq, slip_stat, slip_dir;
  logic [7:0] rd_data;
  logic [5:0] dly_meas;

  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  tx_slip_buffer u_tx_slip_buffer (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_sof(wr_sof),
    .wr_data(wr_data), .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_sof(rd_sof),
    .rd_data(rd_data), .cfg_dly_we(cfg_dly_we), .cfg_dly(cfg_dly), .dly_meas(dly_meas),
    .irq_mask(irq_mask), .slip_irq(slip_irq), .slip_stat(slip_stat), .slip_dir(slip_dir)
  );

  // behavioural reference
  byte unsigned m_mem [48];
  int m_wp = 0, m_rp = 0, m_next = 0, m_meas = 0;
  bit m_irq = 0, m_stat = 0, m_dir = 0;
  int m_repeats = 0, m_skips = 0;
  int irq_seen = 0;

  initial for (int i = 0; i < 48; i++) m_mem[i] = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_wp = 0; m_rp = 0; m_next = 0; m_meas = 0; m_irq = 0; m_stat = 0; m_dir = 0;
      for (int i = 0; i < 48; i++) m_mem[i] = 0;
    end else begin
      int slot, cand, d, pv;
      m_irq = 0;
      if (cfg_dly_we) begin
        pv = (cfg_dly > 23) ? 23 : int'(cfg_dly);
        m_rp = (m_wp - pv + 48) % 48;
        m_meas = pv;
      end else if (rd_ready) begin
        cand = (m_rp + 1) % 48;
        if (cand % 24 == 0) begin
          d = (m_wp - cand + 48) % 48;
          if (d < 4 || d > 40) begin
            if (d < 4) begin m_dir = 1; m_repeats++; end
            else begin m_dir = 0; m_skips++; end
            m_stat = ~m_stat;
            m_irq = !irq_mask;
            cand = (cand + 24) % 48;
            d = (m_wp - cand + 48) % 48;
          end
          m_meas = d;
        end
        m_rp = cand;
      end
      if (wr_valid) begin
        slot = wr_sof ? 0 : m_next;
        m_next = (slot + 1) % 32;
        if (slot >= 1 && slot <= 24) begin
          m_mem[m_wp] = wr_data;
          m_wp = (m_wp + 1) % 48;
        end
      end
    end
  end

  task automatic fail(input string req, input string what, input int act, input int exp);
    errors++;
    $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
  endtask

  // R1 R2 R3 R6 R7: compare against the model every cycle
  always @(negedge clk) begin
    if (!done) begin
      checks++;
      if (rd_data !== m_mem[m_rp]) fail("R2/R3", "rd_data", rd_data, m_mem[m_rp]);
      if (rd_sof !== (m_rp % 24 == 0)) fail("R3", "rd_sof", rd_sof, m_rp % 24 == 0);
      if (dly_meas !== 6'(m_meas)) fail("R7", "dly_meas", dly_meas, m_meas);
      if (slip_stat !== m_stat) fail("R6", "slip_stat", slip_stat, m_stat);
      if (slip_dir !== m_dir) fail("R6", "slip_dir", slip_dir, m_dir);
      if (slip_irq !== m_irq) fail("R6", "slip_irq", slip_irq, m_irq);
      if (wr_ready !== !rst) fail("R1", "wr_ready", wr_ready, !rst);
      if (rd_valid !== !rst) fail("R1", "rd_valid", rd_valid, !rst);
      if (slip_irq === 1'b1) irq_seen++;
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) fail(req, what, act, exp);
  endtask

  int cyc = 0;
  int rd_mode = 0;  // 0 off, 1 three of four, 2 seven of eight, 3 two of three
  int wr_gap = 0;
  byte unsigned lfsr = 8'h5a;

  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #2;
      cyc++;
      cfg_dly_we = 0;
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      wr_valid = !(wr_gap != 0 && cyc % 7 == 6);
      wr_sof   = wr_valid && (m_next == 0);
      wr_data  = lfsr;
      case (rd_mode)
        1: rd_ready = (cyc % 4 != 3);
        2: rd_ready = (cyc % 8 != 7);
        3: rd_ready = (cyc % 3 != 2);
        default: rd_ready = 0;
      endcase
    end
  endtask

  task automatic preset(input int v, input bit with_read);
    @(posedge clk); #2;
    wr_valid = 0; rd_ready = with_read; cfg_dly_we = 1; cfg_dly = 6'(v);
    @(posedge clk); #2;
    cfg_dly_we = 0; rd_ready = 0;
  endtask

  initial begin
    int st0, r0, s0, i0;
    repeat (5) @(posedge clk);
    #6;
    // R1: reset state
    check("R1", "rd_valid in reset", rd_valid, 0);
    check("R1", "wr_ready in reset", wr_ready, 0);
    check("R1", "dly_meas in reset", dly_meas, 0);
    @(posedge clk); #2; rst = 0;
    @(negedge clk);
    check("R1", "wr_ready after reset", wr_ready, 1);

    // R2: fill one backplane frame, no reads
    rd_mode = 0; run(32);
    // R8: preset to 12
    preset(12, 0);
    @(negedge clk);
    check("R8", "dly_meas after preset", dly_meas, 12);

    // R9: matched rates, no slips
    st0 = slip_stat; r0 = m_repeats; s0 = m_skips;
    rd_mode = 1; run(320);
    @(negedge clk);
    check("R9", "slip_stat unchanged at matched rate", slip_stat, st0);
    check("R9", "model slips at matched rate", m_repeats + m_skips, r0 + s0);

    // R4: reader faster, repeats with interrupt
    irq_mask = 0; i0 = irq_seen; r0 = m_repeats; wr_gap = 1;
    rd_mode = 2; run(300);
    @(negedge clk);
    check("R4", "repeat slips occurred", int'(m_repeats > r0), 1);
    check("R4", "slip_dir after repeat", slip_dir, 1);
    check("R6", "interrupts equal repeats", irq_seen - i0, m_repeats - r0);

    // R5: writer faster with mask, skips without interrupt
    wr_gap = 0; irq_mask = 1; i0 = irq_seen; s0 = m_skips;
    rd_mode = 3; run(900);
    @(negedge clk);
    check("R5", "skip slips occurred", int'(m_skips > s0), 1);
    check("R5", "slip_dir after skip", slip_dir, 0);
    check("R6", "no interrupt while masked", irq_seen - i0, 0);

    // R8: clamp and priority over a read beat
    rd_mode = 0;
    preset(40, 1);
    @(negedge clk);
    check("R8", "clamped preset", dly_meas, 23);
    preset(0, 0);
    @(negedge clk);
    check("R8", "zero preset", dly_meas, 0);
    irq_mask = 0; rd_mode = 1; run(100);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 100000);
    done = 1;
    errors++;
    $display("FAIL R1 watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule